// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This controller sits in a board-management device and loads two daisy-chained FPGAs from a byte-wide parallel flash. When a load is launched, it pulls the chain's program line low for a set number of cycles. It then waits for the chain to signal readiness on its init line and streams a fixed-length image from the flash. Each byte goes out most significant bit first on a data pin, with a configuration clock generated alongside it. The first device in the chain takes the leading part of the image, which sits at the low end of the selected bank. The second device takes the part that follows it directly.

The devices' completion pins are not wired back, so the loader ends on a byte count rather than on device feedback. After the last data bit it issues a fixed number of extra clock pulses so the devices can finish start-up, then reports done. Three static switches set the behaviour:
- one picks one of two flash banks (offset 0 or a high offset);
- one decides whether a load starts by itself after reset;
- one decides whether a falling edge on the host bus reset restarts a full load.

A drop of the init line during streaming aborts the load with an error.

Inside the block, a flash prefetch stage hands bytes to the serializer over a valid/ready pair. The prefetch stage holds a byte until the serializer takes it, and it starts the next flash read only after that hand-over. The serializer takes a byte only in the cycle that ends the previous byte's last bit, or when it is empty. The host reset line is assumed synchronous to `clk`.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is held: prog_n is 1, cclk is 0, fl_ce_n and fl_oe_n are 1, and busy, done and err are 0.
- R2: With sw_auto_cfg=1, a load launches in the first cycle after reset release without any start pulse. With sw_auto_cfg=0, the block stays idle (busy=0) until a one-cycle start pulse arrives.
- R3: A launch drives prog_n low for exactly PROG_LOW_CYC cycles. No cclk rising edge occurs afterwards until init_n is seen high.
- R4: Image bytes are read at ascending flash addresses, one address per byte. The first address is 0 when sw_bank_hi=0 and BANK_HI_OFS when sw_bank_hi=1. The flash address is held steady for the whole time fl_oe_n is low.
- R5: Each byte is shifted out most significant bit first, with one cclk rising edge per bit. din is stable across each cclk rising edge.
- R6: cclk has a period of exactly two clk cycles (one cycle high, one cycle low) across all data bits, including byte boundaries, provided RD_WAIT is at most 15.
- R7: A completed load gives exactly 8*IMG_BYTES data edges followed by TAIL_CCLK extra cclk rising edges. After that, done=1 and busy=0.
- R8: If init_n goes low while data is streaming, err becomes 1, busy returns to 0, cclk stops and the flash is deselected (fl_oe_n=1).
- R9: A start pulse while busy has no effect: the load in progress continues and completes with the full edge count.
- R10: With sw_hostrst_en=1, a falling edge on host_rst_n restarts the load from the program pulse, in any state. With sw_hostrst_en=0, the edge is ignored.
- R11: A new launch clears both done and err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_bank_hi | input | 1 | Bank select switch: 1 = high flash offset, 0 = offset 0 |
| sw_auto_cfg | input | 1 | 1 = launch a load right after reset |
| sw_hostrst_en | input | 1 | 1 = host reset falling edge restarts the load |
| host_rst_n | input | 1 | Host bus reset, active low, synchronous to clk |
| start | input | 1 | One-cycle launch request, honoured only while idle |
| init_n | input | 1 | Chain init line, high when the devices accept data |
| fl_data | input | 8 | Flash read data |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| prog_n | output | 1 | Chain program line, active low |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Configuration serial data |
| busy | output | 1 | A load sequence is in progress |
| done | output | 1 | Last load completed by byte count |
| err | output | 1 | Last load aborted by init_n dropping |

## Verification
The hardest situations to reach from the ports are the ones where an event lands in the middle of streaming. These are a host reset, a stray start pulse or an init drop that arrives while bytes and the prefetch read overlap. The bench counts cclk rising edges as they happen and injects these events a fixed number of cycles after init_n goes high, so each one hits a load that is already running. It then checks that the restarted load produces a complete, bit-exact stream from the selected bank. For an abort, it checks that cclk stays silent afterwards.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WINIT,
    ST_STREAM,
    ST_TAIL
  } ld_state_t;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_WAIT,
    FS_FULL
  } fetch_state_t;
endpackage

// File: rtl/cfgld_fetch.sv
module cfgld_fetch
  import cfgld_pkg::*;
#(
  parameter int          ADDR_W      = 23,
  parameter int unsigned BANK_HI_OFS = 32'h0040_0000,
  parameter int          IMG_BYTES   = 3145728,
  parameter int          RD_WAIT     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fstart,
  input  logic              bank_hi,
  input  logic              take,
  input  logic [BYTE_W-1:0] fl_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              valid,
  output logic [BYTE_W-1:0] byte_q,
  output logic              idle
);
  localparam int LW  = $clog2(IMG_BYTES + 1);
  localparam int WCW = $clog2(RD_WAIT + 1);

  fetch_state_t      fs;
  logic [ADDR_W-1:0] addr;
  logic [LW-1:0]     left;
  logic [WCW-1:0]    wcnt;
  logic [BYTE_W-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      fs    <= FS_IDLE;
      addr  <= '0;
      left  <= '0;
      wcnt  <= '0;
      buf_q <= '0;
    end else if (fstart) begin
      addr <= bank_hi ? ADDR_W'(BANK_HI_OFS) : '0;
      left <= LW'(IMG_BYTES);
      wcnt <= '0;
      fs   <= FS_WAIT;
    end else begin
      case (fs)
        FS_WAIT: begin
          if (wcnt == WCW'(RD_WAIT - 1)) begin
            buf_q <= fl_data;
            addr  <= addr + 1'b1;
            left  <= left - 1'b1;
            fs    <= FS_FULL;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        FS_FULL: begin
          if (take) begin
            wcnt <= '0;
            fs   <= (left != '0) ? FS_WAIT : FS_IDLE;
          end
        end
        default: fs <= FS_IDLE;
      endcase
    end
  end

  assign fl_addr = addr;
  assign fl_oe_n = (fs != FS_WAIT);
  assign fl_ce_n = (fs != FS_WAIT);
  assign valid   = (fs == FS_FULL);
  assign byte_q  = buf_q;
  assign idle    = (fs == FS_IDLE);

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!fl_oe_n) && !fl_oe_n) |-> $stable(fl_addr)) else $error("AST_ADDR_HELD"); // R4
  AST_READ_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_oe_n && !$past(fl_oe_n)) |-> left != '0) else $error("AST_READ_BOUNDED"); // R7
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift
  import cfgld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              rdy,
  output logic              take,
  output logic              active,
  output logic              cclk,
  output logic              din
);
  localparam int BCW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh;
  logic [BCW-1:0]    bcnt;
  logic              ph;
  logic              act;
  logic              ck;
  logic              last_bit;

  assign last_bit = (bcnt == BCW'(BYTE_W - 1));
  assign rdy      = en && (!act || (ph && last_bit));
  assign take     = rdy && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      sh   <= '0;
      bcnt <= '0;
      ph   <= 1'b0;
      act  <= 1'b0;
      ck   <= 1'b0;
    end else if (take) begin
      sh   <= in_byte;
      bcnt <= '0;
      ph   <= 1'b0;
      act  <= 1'b1;
      ck   <= 1'b0;
    end else if (act) begin
      if (!ph) begin
        ck <= 1'b1;
        ph <= 1'b1;
      end else begin
        ck <= 1'b0;
        ph <= 1'b0;
        if (last_bit) begin
          act <= 1'b0;
        end else begin
          sh   <= {sh[BYTE_W-2:0], 1'b0};
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  assign active = act;
  assign cclk   = ck;
  assign din    = sh[BYTE_W-1];

  AST_DIN_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ck) |-> $stable(sh[BYTE_W-1])) else $error("AST_DIN_SETTLED"); // R5
  AST_CCLK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n || flush)
    ck |=> !ck) else $error("AST_CCLK_ONE_HIGH"); // R6
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int PROG_LOW_CYC = 64,
  parameter int TAIL_CCLK    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_auto_cfg,
  input  logic sw_hostrst_en,
  input  logic host_rst_n,
  input  logic start,
  input  logic init_n,
  input  logic f_idle,
  input  logic sh_active,
  output logic flush,
  output logic fstart,
  output logic sh_en,
  output logic tail_cclk,
  output logic prog_n,
  output logic busy,
  output logic done,
  output logic err
);
  localparam int PCW = $clog2(PROG_LOW_CYC + 1);
  localparam int TCW = $clog2(TAIL_CCLK + 1);

  ld_state_t      st;
  logic           boot_q;
  logic           host_q;
  logic [PCW-1:0] pcnt;
  logic [TCW-1:0] tcnt;
  logic           tail_ck;
  logic           done_q;
  logic           err_q;
  logic           retrig;
  logic           launch;
  logic           abort;

  assign retrig = host_q && !host_rst_n && sw_hostrst_en;
  assign launch = retrig || ((st == ST_IDLE) && ((boot_q && sw_auto_cfg) || start));
  assign abort  = (st == ST_STREAM) && !init_n && !retrig;
  assign flush  = launch || abort;
  assign fstart = (st == ST_WINIT) && init_n && !retrig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      boot_q  <= 1'b1;
      host_q  <= 1'b1;
      pcnt    <= '0;
      tcnt    <= '0;
      tail_ck <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      host_q <= host_rst_n;
      if (st == ST_IDLE) boot_q <= 1'b0;
      if (launch) begin
        st      <= ST_PROG;
        pcnt    <= '0;
        tcnt    <= '0;
        tail_ck <= 1'b0;
        done_q  <= 1'b0;
        err_q   <= 1'b0;
      end else begin
        case (st)
          ST_PROG: begin
            if (pcnt == PCW'(PROG_LOW_CYC - 1)) st <= ST_WINIT;
            else pcnt <= pcnt + 1'b1;
          end
          ST_WINIT: begin
            if (init_n) st <= ST_STREAM;
          end
          ST_STREAM: begin
            if (!init_n) begin
              err_q <= 1'b1;
              st    <= ST_IDLE;
            end else if (f_idle && !sh_active) begin
              tail_ck <= 1'b0;
              tcnt    <= '0;
              st      <= ST_TAIL;
            end
          end
          ST_TAIL: begin
            tail_ck <= !tail_ck;
            if (tail_ck) begin
              if (tcnt == TCW'(TAIL_CCLK - 1)) begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                tcnt <= tcnt + 1'b1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign sh_en     = (st == ST_STREAM);
  assign tail_cclk = tail_ck;
  assign prog_n    = (st != ST_PROG);
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  AST_PROG_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n) |-> $past(pcnt) == PCW'(PROG_LOW_CYC - 1)) else $error("AST_PROG_WIDTH"); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("AST_DONE_IDLE"); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(!init_n)) else $error("AST_ERR_CAUSE"); // R8
  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !retrig) |=> !$fell(prog_n)) else $error("AST_NO_RELAUNCH"); // R9
  AST_HOST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    retrig |=> !prog_n) else $error("AST_HOST_RESTART"); // R10
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgld_pkg::*;
#(
  parameter int          ADDR_W       = 23,
  parameter int unsigned BANK_HI_OFS  = 32'h0040_0000,
  parameter int          IMG_BYTES    = 3145728,
  parameter int          PROG_LOW_CYC = 64,
  parameter int          RD_WAIT      = 4,
  parameter int          TAIL_CCLK    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_bank_hi,
  input  logic              sw_auto_cfg,
  input  logic              sw_hostrst_en,
  input  logic              host_rst_n,
  input  logic              start,
  input  logic              init_n,
  input  logic [7:0]        fl_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              prog_n,
  output logic              cclk,
  output logic              din,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic              flush;
  logic              fstart;
  logic              sh_en;
  logic              tail_cclk;
  logic              f_valid;
  logic              f_idle;
  logic [BYTE_W-1:0] f_byte;
  logic              sh_rdy;
  logic              sh_take;
  logic              sh_active;
  logic              sh_cclk;

  cfgld_seq #(
    .PROG_LOW_CYC(PROG_LOW_CYC),
    .TAIL_CCLK   (TAIL_CCLK)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_auto_cfg  (sw_auto_cfg),
    .sw_hostrst_en(sw_hostrst_en),
    .host_rst_n   (host_rst_n),
    .start        (start),
    .init_n       (init_n),
    .f_idle       (f_idle),
    .sh_active    (sh_active),
    .flush        (flush),
    .fstart       (fstart),
    .sh_en        (sh_en),
    .tail_cclk    (tail_cclk),
    .prog_n       (prog_n),
    .busy         (busy),
    .done         (done),
    .err          (err)
  );

  cfgld_fetch #(
    .ADDR_W     (ADDR_W),
    .BANK_HI_OFS(BANK_HI_OFS),
    .IMG_BYTES  (IMG_BYTES),
    .RD_WAIT    (RD_WAIT)
  ) u_fetch (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .fstart (fstart),
    .bank_hi(sw_bank_hi),
    .take   (sh_take),
    .fl_data(fl_data),
    .fl_addr(fl_addr),
    .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n),
    .valid  (f_valid),
    .byte_q (f_byte),
    .idle   (f_idle)
  );

  cfgld_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .en      (sh_en),
    .in_valid(f_valid),
    .in_byte (f_byte),
    .rdy     (sh_rdy),
    .take    (sh_take),
    .active  (sh_active),
    .cclk    (sh_cclk),
    .din     (din)
  );

  assign cclk = sh_cclk | tail_cclk;

  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_active && sh_rdy && !f_idle) |-> f_valid) else $error("AST_NO_UNDERRUN"); // R6
  AST_FLASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_oe_n && fl_ce_n)) else $error("AST_FLASH_QUIET"); // R8
endmodule

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;
  localparam int IMG  = 5;
  localparam int PLC  = 4;
  localparam int TAIL = 3;
  localparam int RDW  = 5;
  localparam logic [22:0] HI_BASE = 23'h400000;
  // row: {bank_hi, init_delay[3:0], mid_event[1:0]}; mid 0 none, 1 start, 2 host reset (disabled)
  localparam logic [6:0] TBL [0:3] = '{7'b0_0010_00, 7'b1_0011_00, 7'b0_0000_01, 7'b1_0101_10};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_bank_hi = 1'b0, sw_auto_cfg = 1'b0, sw_hostrst_en = 1'b0;
  logic host_rst_n = 1'b1, start = 1'b0, init_n = 1'b0;
  logic [7:0]  fl_data;
  logic [22:0] fl_addr;
  logic fl_ce_n, fl_oe_n, prog_n, cclk, din, busy, done, err;

  int checks = 0, errors = 0;
  int tot_e = 0, tot_pl = 0, gap = 0;
  logic cprev = 1'b0;
  logic cap_bit [0:511];
  int   cap_gap [0:511];

  always #2 clk = ~clk;

  function automatic logic [7:0] fdat(input logic [22:0] a);
    return a[7:0] ^ a[22:15] ^ 8'h5A;
  endfunction

  assign fl_data = (!fl_ce_n && !fl_oe_n) ? fdat(fl_addr) : 8'hFF;

  cfg_serial_loader #(
    .IMG_BYTES(IMG), .PROG_LOW_CYC(PLC), .RD_WAIT(RDW), .TAIL_CCLK(TAIL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sw_bank_hi(sw_bank_hi), .sw_auto_cfg(sw_auto_cfg),
    .sw_hostrst_en(sw_hostrst_en), .host_rst_n(host_rst_n), .start(start),
    .init_n(init_n), .fl_data(fl_data), .fl_addr(fl_addr), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .prog_n(prog_n), .cclk(cclk), .din(din), .busy(busy),
    .done(done), .err(err)
  );

  always @(negedge clk) begin
    if (!prog_n) tot_pl++;
    gap++;
    if (cclk && !cprev) begin
      cap_bit[tot_e % 512] = din;
      cap_gap[tot_e % 512] = gap;
      gap = 0;
      tot_e++;
    end
    cprev = cclk;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic complete_load(input logic bank, input int idelay, input int mid);
    int e0, p0, t, gbad;
    logic [7:0] got;
    logic [22:0] base;
    #1;
    e0 = tot_e; p0 = tot_pl;
    base = bank ? HI_BASE : 23'h0;
    @(negedge clk); start = 1'b0; host_rst_n = 1'b1;
    t = 0; while (prog_n && t < 100) begin @(negedge clk); t++; end
    chk(!prog_n, "R3 program pulse seen", int'(prog_n), 0);
    t = 0; while (!prog_n && t < 100) begin @(negedge clk); t++; end
    chk(tot_pl - p0 == PLC, "R3 program width", tot_pl - p0, PLC);
    repeat (idelay) @(negedge clk);
    chk(tot_e == e0, "R3 no cclk before init", tot_e - e0, 0);
    init_n = 1'b1;
    if (mid != 0) begin
      repeat (25) @(negedge clk);
      if (mid == 1) start = 1'b1; else host_rst_n = 1'b0;
      @(negedge clk); start = 1'b0; host_rst_n = 1'b1;
    end
    t = 0; while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done && !busy, "R7 done after load", int'(done), 1);
    chk(tot_e - e0 == 8*IMG + TAIL, "R7 R9 R10 edge count", tot_e - e0, 8*IMG + TAIL);
    gbad = 0;
    for (int i = 1; i < 8*IMG; i++) if (cap_gap[(e0 + i) % 512] != 2) gbad++;
    chk(gbad == 0, "R6 continuous cclk", gbad, 0);
    for (int k = 0; k < IMG; k++) begin
      for (int j = 0; j < 8; j++) got[7-j] = cap_bit[(e0 + 8*k + j) % 512];
      chk(got == fdat(base + 23'(k)), "R4 R5 stream byte", int'(got), int'(fdat(base + 23'(k))));
    end
    init_n = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(prog_n && !cclk && fl_ce_n && fl_oe_n, "R1 pins in reset", int'({prog_n, cclk, fl_ce_n, fl_oe_n}), 4'b1011);
    chk(!busy && !done && !err, "R1 status in reset", int'({busy, done, err}), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!busy && prog_n, "R2 no auto start when switch off", int'(busy), 0);

    for (int r = 0; r < 4; r++) begin
      sw_bank_hi = TBL[r][6];
      sw_hostrst_en = 1'b0;
      start = 1'b1;
      complete_load(TBL[r][6], int'(TBL[r][5:2]), int'(TBL[r][1:0]));
      repeat (4) @(negedge clk);
    end

    // R2: auto launch after reset
    rst_n = 1'b0; sw_auto_cfg = 1'b1; sw_bank_hi = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy, "R1 busy low in reset", int'(busy), 0);
    rst_n = 1'b1;
    complete_load(1'b0, 1, 0);
    sw_auto_cfg = 1'b0;
    repeat (4) @(negedge clk);

    // R10: host reset restart mid-stream
    sw_hostrst_en = 1'b1; sw_bank_hi = 1'b1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!prog_n) @(negedge clk);
    init_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(busy && tot_e > 0, "R10 load running before restart", int'(busy), 1);
    host_rst_n = 1'b0; init_n = 1'b0;
    complete_load(1'b1, 2, 0);
    sw_hostrst_en = 1'b0;
    repeat (4) @(negedge clk);

    // R8: init drop aborts
    sw_bank_hi = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!prog_n) @(negedge clk);
    init_n = 1'b1;
    repeat (30) @(negedge clk);
    init_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(err && !busy, "R8 err set and idle", int'({err, busy}), 2);
    chk(fl_oe_n && fl_ce_n && !cclk, "R8 flash deselected", int'({fl_oe_n, fl_ce_n}), 3);
    e = tot_e;
    repeat (20) @(negedge clk);
    chk(tot_e == e, "R8 cclk stopped", tot_e - e, 0);

    // R11: relaunch clears err (and done was cleared at earlier launch)
    start = 1'b1; @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(!err && !done && busy, "R11 flags cleared on launch", int'({err, done, busy}), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule